// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switch

This block picks one of two free-running input clocks and passes it to a single output clock without runt pulses. A rising edge on the switch request input moves the selection to the other input. The handover has two steps. First the outgoing clock is gated off on one of its own falling edges. Then the incoming clock is enabled on one of its own falling edges, once the incoming side has seen that the outgoing gate is closed. A status output reports which input currently drives the output.

Each input has an activity monitor clocked by a free-running check clock. The monitor raises a loss flag when its input shows no edges for a whole observation window. A switch request toward a clock that is flagged as lost is held, and the output keeps running on the current clock. The switch completes on its own once the target clock has been seen toggling for a full window. The check clock also runs the request edge detector and the sequencing control. Every value that crosses between clock domains passes through a multi-flop synchronizer.

Top module: `refclk_switch`

## Requirements
- R1: During and after a synchronous active-high reset, input A is selected. `sel_now` is 0, `clk_out` follows `clk_a`, and both loss flags are 0.
- R2: A rising edge on `swap_req` moves the output to the other input. `sel_now` then reads 1 when `clk_b` drives `clk_out` and 0 when `clk_a` does.
- R3: A falling edge on `swap_req` has no effect on the selection.
- R4: Across every handover, no high or low phase of `clk_out` is shorter than the shorter half-period of the two inputs.
- R5: The outgoing clock's gate is closed before the incoming clock's gate opens, so the two gates are never open at the same time.
- R6: A further rising edge on `swap_req` after a finished switch moves the output back to the first input.
- R7: A rising edge on `swap_req` that arrives while a handover is still in progress is remembered. It starts one more handover once the current one finishes.
- R8: A loss flag rises when its input shows no edges for a whole window of `WINDOW` check-clock cycles. It falls after a whole window in which the input toggled.
- R9: While the target input is flagged as lost, a requested switch waits, `sel_now` keeps its value and `clk_out` keeps following the current input. The switch completes after the target's flag clears.
- R10: During a switch where both inputs run, neither loss flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| chk_clk | input | 1 | Free-running check and control clock |
| rst | input | 1 | Synchronous active-high reset, check-clock domain |
| clk_a | input | 1 | Input clock A (selected after reset) |
| clk_b | input | 1 | Input clock B |
| swap_req | input | 1 | Switch request, acts on its rising edge |
| clk_out | output | 1 | Gated, glitch-free output clock |
| sel_now | output | 1 | 0: clk_a drives clk_out, 1: clk_b drives clk_out |
| lost_a | output | 1 | clk_a shows no activity |
| lost_b | output | 1 | clk_b shows no activity |

## Verification
The bench builds the block with its defaults: a 16-cycle observation window and two synchronizer stages. Inputs run at 10 ns and 14 ns against an 8 ns check clock, so the clocks are unrelated in phase. With a short window, the bench can stop `clk_b`, see its loss flag rise, show a held request and then show it completing, all within a few hundred cycles. The two handover chains have different lengths, which leaves room to land a second request in the middle of a handover.

// File: rtl/refsw_pkg.sv
`timescale 1ns/1ps
package refsw_pkg;
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;

  function automatic src_e other_src(input src_e s);
    return (s == SRC_A) ? SRC_B : SRC_A;
  endfunction
endpackage

// File: rtl/refsw_sync.sv
`timescale 1ns/1ps
// Plain multi-flop synchronizer; each bit is independent.
module refsw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/refsw_branch.sv
`timescale 1ns/1ps
// One leg of the clock switch, living in its own input clock domain.
// The gate opens only when this leg is wanted and the peer gate is seen
// closed; the gate register itself moves on the falling edge, while the
// input clock is low, so gating never cuts a pulse.
module refsw_branch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst,      // check-clock domain
  input  logic want,     // check-clock domain
  input  logic peer_en,  // peer clock domain
  output logic en
);
  logic rst_i;
  logic want_s;
  logic peer_s;
  logic gate_d;

  refsw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk_i), .d(rst), .q(rst_i)
  );

  refsw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_want_sync (
    .clk(clk_i), .d(want), .q(want_s)
  );

  refsw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_peer_sync (
    .clk(clk_i), .d(peer_en), .q(peer_s)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) gate_d <= 1'b0;
    else       gate_d <= want_s & ~peer_s;
  end

  always_ff @(negedge clk_i) begin
    if (rst_i) en <= 1'b0;
    else       en <= gate_d;
  end
endmodule

// File: rtl/refsw_activity_mon.sv
`timescale 1ns/1ps
// Watches one input clock from the check-clock domain. A divide-by-two
// toggle in the watched domain is synchronized; any change counts as
// activity. The toggle's start value is irrelevant, only its changes are.
module refsw_activity_mon #(
  parameter int WINDOW      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic chk_clk,
  input  logic rst,
  input  logic mon_clk,
  output logic lost
);
  localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  logic             tog;
  logic             tog_s;
  logic             tog_q;
  logic             act;
  logic             seen;
  logic [CNT_W-1:0] wcnt;

  always_ff @(posedge mon_clk) tog <= ~tog;

  refsw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_tog_sync (
    .clk(chk_clk), .d(tog), .q(tog_s)
  );

  assign act = tog_s ^ tog_q;

  always_ff @(posedge chk_clk) begin
    if (rst) begin
      tog_q <= 1'b0;
      wcnt  <= '0;
      seen  <= 1'b0;
      lost  <= 1'b0;
    end else begin
      tog_q <= tog_s;
      if (wcnt == LAST) begin
        wcnt <= '0;
        lost <= ~(seen | act);
        seen <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
        seen <= seen | act;
      end
    end
  end

  // Checker: count consecutive quiet cycles (saturating).
  localparam logic [CNT_W:0] QMAX = (CNT_W+1)'(WINDOW);
  logic [CNT_W:0] quiet;
  always_ff @(posedge chk_clk) begin
    if (rst)               quiet <= '0;
    else if (act)          quiet <= '0;
    else if (quiet != QMAX) quiet <= quiet + 1'b1;
  end

  p_lost_after_quiet_r8: assert property (@(posedge chk_clk) disable iff (rst)
    $rose(lost) |-> (int'($past(quiet)) >= WINDOW - 1));
endmodule

// File: rtl/refsw_ctrl.sv
`timescale 1ns/1ps
// Check-clock sequencer: request edge detection, pending latch,
// availability wait and the reported selection.
module refsw_ctrl
  import refsw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic lost_a,
  input  logic lost_b,
  input  logic en_a_s,
  input  logic en_b_s,
  output logic target,
  output logic sel_now
);
  src_e tgt;
  src_e shown;
  logic req_d;
  logic pending;
  logic req_edge;
  logic done;
  logic dest_lost;
  logic go;

  assign req_edge  = req_s & ~req_d;
  assign done      = (tgt == SRC_B) ? (en_b_s & ~en_a_s) : (en_a_s & ~en_b_s);
  // the clock a new switch would move to is the one not targeted now
  assign dest_lost = (tgt == SRC_B) ? lost_a : lost_b;
  assign go        = (req_edge | pending) & done & (shown == tgt) & ~dest_lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d   <= req_s;
      pending <= 1'b0;
      tgt     <= SRC_A;
      shown   <= SRC_A;
    end else begin
      req_d <= req_s;
      if (go) begin
        tgt     <= other_src(tgt);
        pending <= 1'b0;
      end else if (req_edge) begin
        pending <= 1'b1;
      end
      if (done) shown <= tgt;
    end
  end

  assign target  = (tgt == SRC_B);
  assign sel_now = (shown == SRC_B);
endmodule

// File: rtl/refclk_switch.sv
`timescale 1ns/1ps
module refclk_switch #(
  parameter int WINDOW      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic chk_clk,
  input  logic rst,
  input  logic clk_a,
  input  logic clk_b,
  input  logic swap_req,
  output logic clk_out,
  output logic sel_now,
  output logic lost_a,
  output logic lost_b
);
  logic       req_s;
  logic       target;
  logic       en_a;
  logic       en_b;
  logic [1:0] en_s;

  refsw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(chk_clk), .d(swap_req), .q(req_s)
  );

  refsw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_en_sync (
    .clk(chk_clk), .d({en_b, en_a}), .q(en_s)
  );

  refsw_activity_mon #(.WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) u_mon_a (
    .chk_clk(chk_clk), .rst(rst), .mon_clk(clk_a), .lost(lost_a)
  );

  refsw_activity_mon #(.WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) u_mon_b (
    .chk_clk(chk_clk), .rst(rst), .mon_clk(clk_b), .lost(lost_b)
  );

  refsw_ctrl u_ctrl (
    .clk(chk_clk), .rst(rst), .req_s(req_s),
    .lost_a(lost_a), .lost_b(lost_b),
    .en_a_s(en_s[0]), .en_b_s(en_s[1]),
    .target(target), .sel_now(sel_now)
  );

  refsw_branch #(.SYNC_STAGES(SYNC_STAGES)) u_leg_a (
    .clk_i(clk_a), .rst(rst), .want(~target), .peer_en(en_b), .en(en_a)
  );

  refsw_branch #(.SYNC_STAGES(SYNC_STAGES)) u_leg_b (
    .clk_i(clk_b), .rst(rst), .want(target), .peer_en(en_a), .en(en_b)
  );

  assign clk_out = (clk_a & en_a) | (clk_b & en_b);

  p_one_enable_r5: assert property (@(posedge chk_clk) disable iff (rst)
    !(en_s[0] && en_s[1]));

  p_sel_to_target_r2: assert property (@(posedge chk_clk) disable iff (rst)
    (sel_now != $past(sel_now)) |-> (sel_now == target));

  p_wait_target_b_r9: assert property (@(posedge chk_clk) disable iff (rst)
    (!target && lost_b) |=> !target);

  p_wait_target_a_r9: assert property (@(posedge chk_clk) disable iff (rst)
    (target && lost_a) |=> target);
endmodule

// File: tb/test_refclk_switch.sv
`timescale 1ns/1ps
module test_refclk_switch;
  localparam real MIN_PH = 5.0;

  logic chk_clk = 1'b0;
  logic rst = 1'b1;
  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic swap_req = 1'b0;
  logic clk_out, sel_now, lost_a, lost_b;
  bit   run_a = 1'b1;
  bit   run_b = 1'b1;

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  bit armed = 1'b0;
  realtime last_t = 0.0;

  refclk_switch i_refclk_switch (
    .chk_clk(chk_clk), .rst(rst), .clk_a(clk_a), .clk_b(clk_b),
    .swap_req(swap_req), .clk_out(clk_out), .sel_now(sel_now),
    .lost_a(lost_a), .lost_b(lost_b)
  );

  always #4 chk_clk = ~chk_clk;
  always begin #5; if (run_a || clk_a) clk_a = ~clk_a; end
  always begin #7; if (run_b || clk_b) clk_b = ~clk_b; end

  // R4: measure every phase of clk_out
  always @(clk_out) begin
    if (armed && ($realtime - last_t) < MIN_PH - 0.001) glitches++;
    last_t = $realtime;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge chk_clk);
  endtask

  task automatic follows(input bit use_b, input string req);
    int mism = 0;
    for (int i = 0; i < 40; i++) begin
      #1.37;
      if (clk_out !== (use_b ? clk_b : clk_a)) mism++;
    end
    @(negedge chk_clk);
    check(mism == 0, req, mism, 0);
  endtask

  task automatic pulse_req();
    swap_req = 1'b1;
    wait_cyc(4);
    swap_req = 1'b0;
  endtask

  task automatic t_reset();
    wait_cyc(6);
    rst = 1'b0;
    wait_cyc(20);
    check(sel_now == 1'b0, "R1 sel_now", sel_now, 0);
    check(lost_a == 1'b0, "R1 lost_a", lost_a, 0);
    check(lost_b == 1'b0, "R1 lost_b", lost_b, 0);
    follows(1'b0, "R1 clk_out follows clk_a");
    armed = 1'b1;
  endtask

  task automatic t_switch_to_b();
    swap_req = 1'b1;
    wait_cyc(40);
    check(sel_now == 1'b1, "R2 sel_now after rise", sel_now, 1);
    follows(1'b1, "R2 clk_out follows clk_b");
    check(!lost_a && !lost_b, "R10 no loss flag in switch", {lost_a, lost_b}, 0);
  endtask

  task automatic t_fall_ignored();
    swap_req = 1'b0;
    wait_cyc(40);
    check(sel_now == 1'b1, "R3 sel_now after fall", sel_now, 1);
    follows(1'b1, "R3 clk_out stays on clk_b");
  endtask

  task automatic t_switch_back();
    swap_req = 1'b1;
    wait_cyc(40);
    check(sel_now == 1'b0, "R6 sel_now after second rise", sel_now, 0);
    follows(1'b0, "R6 clk_out back on clk_a");
    swap_req = 1'b0;
    wait_cyc(10);
  endtask

  task automatic t_pending();
    pulse_req();           // starts A->B
    wait_cyc(3);
    pulse_req();           // lands mid-handover, R7
    wait_cyc(100);
    check(sel_now == 1'b0, "R7 latched request returns to A", sel_now, 0);
    follows(1'b0, "R7 clk_out on clk_a after two handovers");
  endtask

  task automatic t_dead_target();
    run_b = 1'b0;
    wait_cyc(64);
    check(lost_b == 1'b1, "R8 lost_b after quiet window", lost_b, 1);
    check(lost_a == 1'b0, "R8 lost_a stays low", lost_a, 0);
    pulse_req();
    wait_cyc(60);
    check(sel_now == 1'b0, "R9 switch held while target lost", sel_now, 0);
    follows(1'b0, "R9 clk_out keeps clk_a");
    run_b = 1'b1;
    wait_cyc(40);
    check(lost_b == 1'b0, "R8 lost_b clears after activity", lost_b, 0);
    wait_cyc(50);
    check(sel_now == 1'b1, "R9 held switch completes", sel_now, 1);
    follows(1'b1, "R9 clk_out on clk_b");
  endtask

  initial begin
    #(20000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_switch_to_b();
    t_fall_ignored();
    t_switch_back();
    t_pending();
    t_dead_target();
    // R4 and R5: no short phase on clk_out over all handovers
    check(glitches == 0, "R4 short output phases", glitches, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule